// File: doc/BRIEF.md
# Loop Exit Predictor

This block predicts the direction of loop-closing branches whose trip count stays the same from one run of the loop to the next. It holds a small two-way set-associative buffer. Each entry belongs to one branch and keeps two 6-bit counters: a learned run length and a running iteration count. Once a run length has been learned, the entry predicts taken on every iteration of a trip and not-taken on the single exit iteration, and then starts over.

The front end presents a fetch address on the lookup port. It gets back, in the same cycle, a flag that says whether a trained entry covers that address, and the predicted direction. The back end reports each resolved conditional branch on the update port. A not-taken outcome that misses the buffer claims an entry: a free way if one exists, otherwise the least recently used way of the set. Later outcomes of that branch teach the entry its run length and keep its iteration count in step. Choosing between this prediction and the predictions of other predictors is left to the caller, which uses the hit flag for that decision.

Top module: `loop_pred_buf`

## Requirements
- R1: While reset is asserted, and after it is released, every entry is empty, so `hit_o` and `pred_taken_o` read 0 for any lookup address.
- R2: The set index is address bits [9:4] and the tag is address bits [15:10]. Address bits [3:0] and the bits above 15 have no effect on the lookup.
- R3: A not-taken outcome that misses the buffer allocates an entry with both counters at 0 and the entry untrained. A taken outcome that misses allocates nothing.
- R4: An entry that is present but untrained gives `hit_o`=0 and `pred_taken_o`=0.
- R5: On an untrained entry, each taken outcome adds one to the iteration count. The next not-taken outcome copies that count into the run length, marks the entry trained and clears the count.
- R6: A trained entry gives `hit_o`=1. It gives `pred_taken_o`=1 while the iteration count is below the run length and 0 when the two are equal. A not-taken outcome at equality clears the count and keeps the entry trained, so the same pattern repeats on every trip.
- R7: On a trained entry, a not-taken outcome below the run length, or a taken outcome at the run length, clears the trained flag. The entry then learns the run length again on the next not-taken outcome.
- R8: A taken outcome on an entry whose iteration count is already 63 invalidates the entry.
- R9: Allocation fills an empty way first and otherwise evicts the least recently used way. Allocating an entry, or updating an entry without invalidating it, makes that way the most recently used one.
- R10: The lookup outputs follow the stored state in the same cycle. The effect of an update appears on the lookup outputs from the cycle after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_pc_i | input | PC_W | Address of the branch being predicted |
| hit_o | output | 1 | A trained entry covers the lookup address |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken; 0 when `hit_o` is 0 |
| upd_valid_i | input | 1 | A resolved conditional branch is presented |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved direction, 1 = taken |

## Verification
The lookup outputs are combinational on the stored entries, so a change to the lookup address is visible within the same cycle. An update is due on the outputs one rising edge after it is presented. The bench drives each update at a falling edge and samples the outputs 1 ns after the next rising edge, at which point exactly one update has been absorbed. For the same-cycle part of R10, one directed test also samples before that edge and expects the old state. The overflow test walks one entry through 63 counted iterations in each of two trips, so each expected value follows directly from the number of outcomes applied.

// File: rtl/loop_pred_pkg.sv
package loop_pred_pkg;

  localparam int unsigned CNT_W = 6;
  localparam int unsigned TAG_W = 6;

  typedef struct packed {
    logic             vld;
    logic             trn;
    logic [TAG_W-1:0] tag;
    logic [CNT_W-1:0] lim;   // learned run length
    logic [CNT_W-1:0] cnt;   // iterations of current trip
  } loop_ent_t;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_ALLOC,
    ACT_COUNT,
    ACT_TRAIN,
    ACT_EXIT_OK,
    ACT_UNTRAIN,
    ACT_DROP
  } loop_act_e;

endpackage

// File: rtl/loop_pred_match.sv
module loop_pred_match
  import loop_pred_pkg::*;
#(
  parameter int unsigned WAYS  = 2,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  loop_ent_t        row_i [WAYS],
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] way_o
);

  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = row_i[w].vld && (row_i[w].tag == tag_i);
  end

  assign hit_o = |hit_vec;

  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) way_o = WAY_W'(w);
    end
  end

endmodule

// File: rtl/loop_pred_step.sv
module loop_pred_step
  import loop_pred_pkg::*;
(
  input  loop_ent_t        cur_i,
  input  logic             hit_i,
  input  logic             taken_i,
  input  logic [TAG_W-1:0] tag_i,
  output loop_ent_t        nxt_o,
  output loop_act_e        act_o
);

  always_comb begin
    nxt_o = cur_i;
    act_o = ACT_NONE;
    if (!hit_i) begin
      if (!taken_i) begin
        act_o = ACT_ALLOC;
        nxt_o = '{vld: 1'b1, trn: 1'b0, tag: tag_i, lim: '0, cnt: '0};
      end
    end else if (taken_i) begin
      if (&cur_i.cnt) begin
        act_o = ACT_DROP;
        nxt_o = '0;
      end else begin
        // taken past the learned exit point: run length is stale
        act_o     = (cur_i.trn && cur_i.cnt == cur_i.lim) ? ACT_UNTRAIN : ACT_COUNT;
        nxt_o.cnt = cur_i.cnt + 1'b1;
        if (act_o == ACT_UNTRAIN) nxt_o.trn = 1'b0;
      end
    end else begin
      nxt_o.cnt = '0;
      if (!cur_i.trn) begin
        act_o     = ACT_TRAIN;
        nxt_o.lim = cur_i.cnt;
        nxt_o.trn = 1'b1;
      end else if (cur_i.cnt == cur_i.lim) begin
        act_o = ACT_EXIT_OK;
      end else begin
        act_o     = ACT_UNTRAIN;
        nxt_o.trn = 1'b0;
      end
    end
  end

endmodule

// File: rtl/loop_pred_victim.sv
module loop_pred_victim
  import loop_pred_pkg::*;
(
  input  loop_ent_t row_i [2],
  input  logic      lru_i,
  output logic      way_o
);

  always_comb begin
    if (!row_i[0].vld)      way_o = 1'b0;
    else if (!row_i[1].vld) way_o = 1'b1;
    else                    way_o = lru_i;
  end

endmodule

// File: rtl/loop_pred_buf.sv
module loop_pred_buf
  import loop_pred_pkg::*;
#(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned IDX_LSB  = 4,
  parameter int unsigned SET_BITS = 6,
  localparam int unsigned SETS    = 1 << SET_BITS,
  localparam int unsigned TAG_LSB = IDX_LSB + SET_BITS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lkp_pc_i,
  output logic            hit_o,
  output logic            pred_taken_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);

  loop_ent_t ent_q [SETS][2];
  logic [SETS-1:0] lru_q;   // way to evict next

  // lookup path
  logic [SET_BITS-1:0] lkp_set;
  logic [TAG_W-1:0]    lkp_tag;
  loop_ent_t           lkp_row [2];
  logic                lkp_hit;
  logic                lkp_way;
  loop_ent_t           lkp_ent;

  assign lkp_set = lkp_pc_i[IDX_LSB +: SET_BITS];
  assign lkp_tag = lkp_pc_i[TAG_LSB +: TAG_W];

  always_comb begin
    for (int w = 0; w < 2; w++) lkp_row[w] = ent_q[lkp_set][w];
  end

  loop_pred_match #(.WAYS(2)) u_lkp_match (
    .row_i (lkp_row),
    .tag_i (lkp_tag),
    .hit_o (lkp_hit),
    .way_o (lkp_way)
  );

  assign lkp_ent      = lkp_row[lkp_way];
  assign hit_o        = lkp_hit && lkp_ent.trn;
  assign pred_taken_o = hit_o && (lkp_ent.cnt < lkp_ent.lim);

  // update path
  logic [SET_BITS-1:0] u_set;
  logic [TAG_W-1:0]    u_tag;
  loop_ent_t           upd_row [2];
  logic                u_hit;
  logic                u_hit_way;
  logic                u_vic_way;
  logic                u_way;
  loop_ent_t           u_old;
  loop_ent_t           u_nxt;
  loop_act_e           u_act;

  assign u_set = upd_pc_i[IDX_LSB +: SET_BITS];
  assign u_tag = upd_pc_i[TAG_LSB +: TAG_W];

  always_comb begin
    for (int w = 0; w < 2; w++) upd_row[w] = ent_q[u_set][w];
  end

  loop_pred_match #(.WAYS(2)) u_upd_match (
    .row_i (upd_row),
    .tag_i (u_tag),
    .hit_o (u_hit),
    .way_o (u_hit_way)
  );

  loop_pred_victim u_victim (
    .row_i (upd_row),
    .lru_i (lru_q[u_set]),
    .way_o (u_vic_way)
  );

  assign u_way = u_hit ? u_hit_way : u_vic_way;
  assign u_old = upd_row[u_way];

  loop_pred_step u_step (
    .cur_i   (u_old),
    .hit_i   (u_hit),
    .taken_i (upd_taken_i),
    .tag_i   (u_tag),
    .nxt_o   (u_nxt),
    .act_o   (u_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        ent_q[s][0] <= '0;
        ent_q[s][1] <= '0;
      end
      lru_q <= '0;
    end else if (upd_valid_i && u_act != ACT_NONE) begin
      ent_q[u_set][u_way] <= u_nxt;
      lru_q[u_set]        <= (u_act == ACT_DROP) ? u_way : ~u_way;
    end
  end

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lkp_pc_i[PC_W-1:TAG_LSB+TAG_W], lkp_pc_i[IDX_LSB-1:0],
                            upd_pc_i[PC_W-1:TAG_LSB+TAG_W], upd_pc_i[IDX_LSB-1:0]};

endmodule

// File: rtl/loop_pred_chk.sv
module loop_pred_chk
  import loop_pred_pkg::*;
#(
  parameter int unsigned SET_BITS = 6,
  localparam int unsigned SETS    = 1 << SET_BITS
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                upd_valid_i,
  input logic                upd_taken_i,
  input logic                u_hit,
  input logic                u_way,
  input logic [SET_BITS-1:0] u_set,
  input logic [TAG_W-1:0]    u_tag,
  input loop_ent_t           u_old,
  input loop_ent_t           ent_q [SETS][2],
  input logic [SETS-1:0]     lru_q
);

  logic [SET_BITS-1:0] set_d;
  logic                way_d;
  logic [TAG_W-1:0]    tag_d;
  loop_ent_t           old_d;
  loop_ent_t           post;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_d <= '0;
      way_d <= 1'b0;
      tag_d <= '0;
      old_d <= '0;
    end else begin
      set_d <= u_set;
      way_d <= u_way;
      tag_d <= u_tag;
      old_d <= u_old;
    end
  end

  assign post = ent_q[set_d][way_d];

  // R3
  alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && !u_hit && !upd_taken_i
    |=> post.vld && !post.trn && post.cnt == '0 && post.tag == tag_d);

  // R5
  train_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && u_hit && !upd_taken_i && !u_old.trn
    |=> post.trn && post.lim == old_d.cnt && post.cnt == '0);

  // R6
  exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && u_hit && !upd_taken_i && u_old.trn && u_old.cnt == u_old.lim
    |=> post.trn && post.cnt == '0 && post.lim == old_d.lim);

  // R7
  retrain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && u_hit && u_old.trn && !(&u_old.cnt) &&
    (upd_taken_i ? (u_old.cnt == u_old.lim) : (u_old.cnt != u_old.lim))
    |=> !post.trn);

  // R8
  overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && u_hit && upd_taken_i && (&u_old.cnt)
    |=> !post.vld);

  // R9
  lru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && (u_hit || !upd_taken_i) && !(u_hit && upd_taken_i && (&u_old.cnt))
    |=> lru_q[set_d] != way_d);

endmodule

bind loop_pred_buf loop_pred_chk #(.SET_BITS(SET_BITS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .upd_valid_i (upd_valid_i),
  .upd_taken_i (upd_taken_i),
  .u_hit       (u_hit),
  .u_way       (u_way),
  .u_set       (u_set),
  .u_tag       (u_tag),
  .u_old       (u_old),
  .ent_q       (ent_q),
  .lru_q       (lru_q)
);

// File: tb/sim_loop_pred_buf.sv
module sim_loop_pred_buf;

  localparam logic [31:0] PC_A = 32'h0000_0120;  // set 0x12, tag 0
  localparam logic [31:0] PC_B = 32'h0000_0520;  // set 0x12, tag 1
  localparam logic [31:0] PC_C = 32'h0000_0920;  // set 0x12, tag 2
  localparam logic [31:0] PC_D = 32'h0000_0030;  // set 0x03, tag 0

  typedef struct packed {
    logic        uv;
    logic        tk;
    logic [31:0] upc;
    logic [31:0] lpc;
    logic        eh;
    logic        ep;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, PC_A, PC_A, 1'b0, 1'b0, 4'd3},   // R3 taken miss: no alloc
    '{1'b1, 1'b0, PC_A, PC_A, 1'b0, 1'b0, 4'd3},   // R3 alloc on not-taken
    '{1'b1, 1'b1, PC_A, PC_A, 1'b0, 1'b0, 4'd4},   // R4 untrained, cnt 1
    '{1'b1, 1'b1, PC_A, PC_A, 1'b0, 1'b0, 4'd4},   // cnt 2
    '{1'b1, 1'b1, PC_A, PC_A, 1'b0, 1'b0, 4'd4},   // cnt 3
    '{1'b1, 1'b0, PC_A, PC_A, 1'b1, 1'b1, 4'd5},   // R5 lim 3
    '{1'b1, 1'b1, PC_A, PC_A, 1'b1, 1'b1, 4'd6},   // R6 cnt 1
    '{1'b1, 1'b1, PC_A, PC_A, 1'b1, 1'b1, 4'd6},   // cnt 2
    '{1'b1, 1'b1, PC_A, PC_A, 1'b1, 1'b0, 4'd6},   // cnt 3: exit predicted
    '{1'b1, 1'b0, PC_A, PC_A, 1'b1, 1'b1, 4'd6},   // exit ok, next trip
    '{1'b1, 1'b1, PC_A, PC_A, 1'b1, 1'b1, 4'd6},   // cnt 1
    '{1'b1, 1'b0, PC_A, PC_A, 1'b0, 1'b0, 4'd7},   // R7 early exit
    '{1'b1, 1'b1, PC_A, PC_A, 1'b0, 1'b0, 4'd7},   // cnt 1
    '{1'b1, 1'b0, PC_A, PC_A, 1'b1, 1'b1, 4'd7},   // relearn lim 1
    '{1'b1, 1'b1, PC_A, PC_A, 1'b1, 1'b0, 4'd6},   // cnt 1 == lim
    '{1'b1, 1'b1, PC_A, PC_A, 1'b0, 1'b0, 4'd7},   // R7 late exit
    '{1'b1, 1'b0, PC_A, PC_A, 1'b1, 1'b1, 4'd7},   // relearn lim 2
    '{1'b0, 1'b0, PC_A, PC_A | 32'h0000_000F, 1'b1, 1'b1, 4'd2},  // R2 low bits ignored
    '{1'b0, 1'b0, PC_A, PC_A | 32'h0001_0000, 1'b1, 1'b1, 4'd2},  // R2 high bits ignored
    '{1'b0, 1'b0, PC_A, PC_A | 32'h0000_0400, 1'b0, 1'b0, 4'd2},  // R2 tag differs
    '{1'b1, 1'b0, PC_B, PC_A, 1'b1, 1'b1, 4'd9},   // R9 B fills free way
    '{1'b1, 1'b0, PC_B, PC_B, 1'b1, 1'b0, 4'd9},   // B lim 0, A now LRU
    '{1'b1, 1'b0, PC_C, PC_A, 1'b0, 1'b0, 4'd9},   // C evicts A
    '{1'b0, 1'b0, PC_C, PC_B, 1'b1, 1'b0, 4'd9}    // B kept
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] lkp_pc;
  logic        hit;
  logic        pred;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic        upd_taken;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  loop_pred_buf u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .lkp_pc_i     (lkp_pc),
    .hit_o        (hit),
    .pred_taken_o (pred),
    .upd_valid_i  (upd_valid),
    .upd_pc_i     (upd_pc),
    .upd_taken_i  (upd_taken)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  task automatic chk(input logic eh, input logic ep, input int r);
    n_vec++;
    if (hit !== eh || pred !== ep) begin
      n_fail++;
      $display("FAIL R%0d: hit=%0b pred=%0b expected hit=%0b pred=%0b", r, hit, pred, eh, ep);
    end
  endtask

  // drive at falling edge, sample 1 ns after the accepting rising edge
  task automatic step(input logic uv, input logic tk, input logic [31:0] upc,
                      input logic [31:0] lpc, input logic eh, input logic ep, input int r);
    @(negedge clk);
    upd_valid = uv;
    upd_taken = tk;
    upd_pc    = upc;
    lkp_pc    = lpc;
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
    chk(eh, ep, r);
  endtask

  initial begin
    rst_n     = 1'b0;
    upd_valid = 1'b0;
    upd_taken = 1'b0;
    upd_pc    = '0;
    lkp_pc    = PC_A;
    #1;
    chk(1'b0, 1'b0, 1);   // R1 during reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(1'b0, 1'b0, 1);   // R1 after release

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].uv, VEC[i].tk, VEC[i].upc, VEC[i].lpc, VEC[i].eh, VEC[i].ep, int'(VEC[i].req));
    end

    // R10: old state visible until the edge, then R7 late exit on B (lim 0)
    @(negedge clk);
    upd_valid = 1'b1;
    upd_taken = 1'b1;
    upd_pc    = PC_B;
    lkp_pc    = PC_B;
    #1;
    chk(1'b1, 1'b0, 10);
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
    chk(1'b0, 1'b0, 10);

    // R8: run D to the counter ceiling
    step(1'b1, 1'b0, PC_D, PC_D, 1'b0, 1'b0, 3);
    for (int i = 0; i < 63; i++) step(1'b1, 1'b1, PC_D, PC_D, 1'b0, 1'b0, 5);
    step(1'b1, 1'b0, PC_D, PC_D, 1'b1, 1'b1, 5);   // lim 63
    for (int i = 1; i <= 63; i++) step(1'b1, 1'b1, PC_D, PC_D, 1'b1, (i < 63), 6);
    step(1'b1, 1'b1, PC_D, PC_D, 1'b0, 1'b0, 8);   // 64th taken: dropped
    step(1'b1, 1'b0, PC_D, PC_D, 1'b0, 1'b0, 8);   // fresh alloc, not a train
    step(1'b1, 1'b1, PC_D, PC_D, 1'b0, 1'b0, 8);
    step(1'b1, 1'b0, PC_D, PC_D, 1'b1, 1'b1, 8);   // lim 1 from a clean count

    // R1: reset in mid-run empties the buffer
    @(negedge clk);
    rst_n  = 1'b0;
    lkp_pc = PC_D;
    #1;
    chk(1'b0, 1'b0, 1);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, PC_D, PC_D, 1'b0, 1'b0, 1);   // R1 state gone: alloc, untrained

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule